// File: doc/BRIEF.md
# Interrupt-capable general-purpose pin controller

This block runs up to 32 general-purpose pins from a single-cycle 32-bit register port. Every pin has a direction bit and an output latch. Software can read back the pin level at any time. Input levels pass through a two-stage synchronizer. Every pin can also act as an interrupt source.

Three configuration words choose each pin's trigger:
- an edge-select bit picks level or edge detection;
- a polarity bit picks the active sense;
- a both-edges bit makes an edge pin fire on either transition.

A raw status word records triggers. A software enable word masks it into a pending word. The pending bits are ORed onto one interrupt line. Writing ones to a clear word drops latched status. A version word reads 3, which tells software that the both-edges mode is present.

Registers are selected by byte address. Only word-aligned addresses (low two bits 00) select a register. A write takes effect at the clock edge on which `bus_we` is high. Reads are combinational on `bus_addr`.

Top module: `pin_ctrl_irq`

## Requirements
- R1: After reset the following hold:
  - the enable word (0x08) reads 0;
  - the pending word (0x10) reads 0;
  - `irq` is 0;
  - the direction word (0x04) reads all ones, so every `pad_oe` bit is 0;
  - the output latch (0x00 write), edge-select, polarity and both-edges words are 0.
- R2: Direction (0x04) bit 1 makes the pin an input and bit 0 makes it an output. For every pin, `pad_oe` is the inverse of its direction bit. `pad_out` carries the output latch, which is written at 0x00. Both outputs change on the edge that takes the write.
- R3: A read of 0x00 returns, for each pin:
  - the synchronized pin level if it is an input, which is `pad_in` delayed by two clock edges;
  - the output latch bit if it is an output.
- R4: With edge-select (0x18) 0, the pin is level-sensitive. The raw status bit (0x0C) follows "level equals polarity (0x1C)". Polarity 1 means active high and 0 means active low. The bit responds on the third rising edge after `pad_in` changes.
- R5: With edge-select 1 and both-edges (0x24) 0, the trigger is a rising edge when polarity is 1 and a falling edge when polarity is 0. The detected edge sets raw status on the third rising edge after the pin changes. The bit stays set after the pin returns, until it is cleared.
- R6: With edge-select 1 and both-edges 1, either transition sets raw status and the polarity bit is ignored.
- R7: Writing the clear word (0x14) has these effects:
  - a bit written 1 clears that pin's raw status on that edge;
  - bits written 0 change nothing;
  - an edge event on the same edge as the clear leaves the bit set;
  - a level pin that is still active sets again on the next edge.
- R8: The pending word (0x10) reads as raw status AND enable (0x08). `irq` is 1 exactly when some pending bit is 1.
- R9: The version word (0x20) reads 3. The clear word (0x14) reads 0. Addresses whose low two bits are not 00 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte address of the register |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pad_in | input | PINS | Asynchronous pin levels |
| pad_out | output | PINS | Output latch driven to the pins |
| pad_oe | output | PINS | Output enable per pin (1 = driving) |
| irq | output | 1 | OR of all pending bits |

## Verification
Neighbouring pins are given different trigger configurations and the same pad waveform. This tells level, rising, falling and both-edge detection apart, and shows whether polarity is ignored in both-edge mode.

Level pins are held active across a clear, which shows whether status re-sets. Edge pins return to idle, which shows whether the status stays latched. A clear write is timed onto the same edge as a new edge event, which exposes whether set or clear has priority.

Pins are split between input and output direction, so the value readback must select between the synchronized level and the output latch per bit.

// File: rtl/pin_ctrl_pkg.sv
package pin_ctrl_pkg;

    localparam int BUS_W = 32;

    // word index = byte address [5:2]
    typedef enum logic [3:0] {
        SEL_LEVEL  = 4'd0,
        SEL_DIR    = 4'd1,
        SEL_ENABLE = 4'd2,
        SEL_RAW    = 4'd3,
        SEL_PEND   = 4'd4,
        SEL_CLEAR  = 4'd5,
        SEL_EDGE   = 4'd6,
        SEL_POL    = 4'd7,
        SEL_VER    = 4'd8,
        SEL_BOTH   = 4'd9
    } reg_sel_e;

    typedef struct packed {
        logic edge_sel;
        logic pol;
        logic both;
    } trig_cfg_t;

    // level mode: active level; edge mode: transition event
    function automatic logic trig_hit(trig_cfg_t c, logic lvl, logic prev);
        logic r;
        if (!c.edge_sel)
            r = (lvl == c.pol);
        else if (c.both)
            r = lvl ^ prev;
        else if (c.pol)
            r = lvl & ~prev;
        else
            r = ~lvl & prev;
        return r;
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int PINS = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PINS-1:0] pad_in,
    output logic [PINS-1:0] lvl,
    output logic [PINS-1:0] prev
);
    logic [PINS-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            lvl    <= '0;
            prev   <= '0;
        end else begin
            stage1 <= pad_in;
            lvl    <= stage1;
            prev   <= lvl;
        end
    end
endmodule

// File: rtl/pin_trig.sv
module pin_trig
    import pin_ctrl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      lvl,
    input  logic      prev,
    input  trig_cfg_t cfg,
    input  logic      clr,
    output logic      raw
);
    logic hit;

    assign hit = trig_hit(cfg, lvl, prev);

    always_ff @(posedge clk) begin
        if (rst)
            raw <= 1'b0;
        else if (cfg.edge_sel)
            raw <= hit | (raw & ~clr);
        else
            raw <= hit & ~clr;
    end
endmodule

// File: rtl/pin_ctrl_regs.sv
module pin_ctrl_regs
    import pin_ctrl_pkg::*;
#(
    parameter int PINS    = 32,
    parameter int VERSION = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [5:0]       bus_addr,
    input  logic             bus_we,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic [PINS-1:0]  lvl,
    input  logic [PINS-1:0]  raw_q,
    output logic [PINS-1:0]  out_q,
    output logic [PINS-1:0]  dir_q,
    output logic [PINS-1:0]  en_q,
    output logic [PINS-1:0]  edge_q,
    output logic [PINS-1:0]  pol_q,
    output logic [PINS-1:0]  both_q,
    output logic [PINS-1:0]  clr_vec
);
    localparam logic [BUS_W-1:0] VER_WORD = BUS_W'(VERSION);

    reg_sel_e        sel;
    logic            aligned;
    logic            wr;
    logic [PINS-1:0] wd;
    logic [PINS-1:0] rd_vec;
    logic            rd_vec_ok;

    assign sel     = reg_sel_e'(bus_addr[5:2]);
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wr      = bus_we && aligned;
    assign wd      = bus_wdata[PINS-1:0];
    assign clr_vec = (wr && sel == SEL_CLEAR) ? wd : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q  <= '0;
            dir_q  <= '1;
            en_q   <= '0;
            edge_q <= '0;
            pol_q  <= '0;
        end else if (wr) begin
            case (sel)
                SEL_LEVEL:  out_q  <= wd;
                SEL_DIR:    dir_q  <= wd;
                SEL_ENABLE: en_q   <= wd;
                SEL_EDGE:   edge_q <= wd;
                SEL_POL:    pol_q  <= wd;
                default: ;
            endcase
        end
    end

    generate
        if (VERSION >= 3) begin : g_both
            always_ff @(posedge clk) begin
                if (rst)
                    both_q <= '0;
                else if (wr && sel == SEL_BOTH)
                    both_q <= wd;
            end
        end else begin : g_no_both
            assign both_q = '0;
        end
    endgenerate

    always_comb begin
        rd_vec    = '0;
        rd_vec_ok = aligned;
        case (sel)
            SEL_LEVEL:  rd_vec = (dir_q & lvl) | (~dir_q & out_q);
            SEL_DIR:    rd_vec = dir_q;
            SEL_ENABLE: rd_vec = en_q;
            SEL_RAW:    rd_vec = raw_q;
            SEL_PEND:   rd_vec = raw_q & en_q;
            SEL_EDGE:   rd_vec = edge_q;
            SEL_POL:    rd_vec = pol_q;
            SEL_BOTH:   rd_vec = both_q;
            default:    rd_vec = '0;
        endcase
        bus_rdata = '0;
        if (rd_vec_ok) begin
            if (sel == SEL_VER)
                bus_rdata = VER_WORD;
            else
                bus_rdata[PINS-1:0] = rd_vec;
        end
    end
endmodule

// File: rtl/pin_ctrl_irq.sv
module pin_ctrl_irq
    import pin_ctrl_pkg::*;
#(
    parameter int PINS    = 32,
    parameter int VERSION = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [5:0]       bus_addr,
    input  logic             bus_we,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic [PINS-1:0]  pad_in,
    output logic [PINS-1:0]  pad_out,
    output logic [PINS-1:0]  pad_oe,
    output logic             irq
);
    logic [PINS-1:0] lvl, prev;
    logic [PINS-1:0] raw_q, out_q, dir_q, en_q, edge_q, pol_q, both_q, clr_vec;

    pin_sync #(.PINS(PINS)) u_sync (
        .clk(clk), .rst(rst), .pad_in(pad_in), .lvl(lvl), .prev(prev)
    );

    pin_ctrl_regs #(.PINS(PINS), .VERSION(VERSION)) u_regs (
        .clk(clk), .rst(rst),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .lvl(lvl), .raw_q(raw_q),
        .out_q(out_q), .dir_q(dir_q), .en_q(en_q),
        .edge_q(edge_q), .pol_q(pol_q), .both_q(both_q),
        .clr_vec(clr_vec)
    );

    generate
        for (genvar i = 0; i < PINS; i++) begin : g_pin
            trig_cfg_t cfg;
            assign cfg = '{edge_sel: edge_q[i], pol: pol_q[i], both: both_q[i]};
            pin_trig u_trig (
                .clk(clk), .rst(rst),
                .lvl(lvl[i]), .prev(prev[i]),
                .cfg(cfg), .clr(clr_vec[i]),
                .raw(raw_q[i])
            );
        end
    endgenerate

    assign pad_out = out_q;
    assign pad_oe  = ~dir_q;
    assign irq     = |(raw_q & en_q);
endmodule

// File: rtl/pin_ctrl_chk.sv
module pin_ctrl_chk #(
    parameter int PINS    = 32,
    parameter int VERSION = 3
) (
    input logic            clk,
    input logic            rst,
    input logic [5:0]      bus_addr,
    input logic            bus_we,
    input logic [31:0]     bus_wdata,
    input logic [31:0]     bus_rdata,
    input logic [PINS-1:0] pad_oe,
    input logic            irq,
    input logic [PINS-1:0] en_q,
    input logic [PINS-1:0] raw_q,
    input logic [PINS-1:0] edge_q,
    input logic [PINS-1:0] clr_vec
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (en_q == '0 && !irq));

    // R8
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (en_q != '0));

    // R2
    dir_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 6'h04) |=> (pad_oe == ~$past(bus_wdata[PINS-1:0])));

    // R7
    edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(raw_q & edge_q & ~clr_vec) & ~raw_q) == '0));

    // R9
    version_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 6'h20) |-> (bus_rdata == 32'(VERSION)));
endmodule

bind pin_ctrl_irq pin_ctrl_chk #(.PINS(PINS), .VERSION(VERSION)) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_oe(pad_oe),
    .irq(irq), .en_q(en_q), .raw_q(raw_q), .edge_q(edge_q),
    .clr_vec(clr_vec)
);

// File: tb/pin_ctrl_irq_test.sv
module pin_ctrl_irq_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe;
    logic        irq;

    int checks = 0;
    int errors = 0;

    pin_ctrl_irq uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference state
    bit [31:0] m_s1, m_s2, m_prev, m_out, m_dir, m_en, m_edge, m_pol, m_both, m_raw;

    always @(posedge clk) begin
        bit [31:0] clr, nraw;
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_out = 0; m_dir = '1;
            m_en = 0; m_edge = 0; m_pol = 0; m_both = 0; m_raw = 0;
        end else begin
            clr = (bus_we && bus_addr == 6'h14) ? bus_wdata : 32'h0;
            for (int i = 0; i < 32; i++) begin
                bit act;
                if (!m_edge[i])      act = (m_s2[i] == m_pol[i]);
                else if (m_both[i])  act = (m_s2[i] != m_prev[i]);
                else if (m_pol[i])   act = m_s2[i] && !m_prev[i];
                else                 act = !m_s2[i] && m_prev[i];
                if (m_edge[i]) nraw[i] = act || (m_raw[i] && !clr[i]);
                else           nraw[i] = act && !clr[i];
            end
            m_raw = nraw;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pad_in;
            if (bus_we) begin
                case (bus_addr)
                    6'h00: m_out  = bus_wdata;
                    6'h04: m_dir  = bus_wdata;
                    6'h08: m_en   = bus_wdata;
                    6'h18: m_edge = bus_wdata;
                    6'h1C: m_pol  = bus_wdata;
                    6'h24: m_both = bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic bit [31:0] exp_read(input bit [5:0] a);
        case (a)
            6'h00: return (m_dir & m_s2) | (~m_dir & m_out);
            6'h04: return m_dir;
            6'h08: return m_en;
            6'h0C: return m_raw;
            6'h10: return m_raw & m_en;
            6'h18: return m_edge;
            6'h1C: return m_pol;
            6'h20: return 32'd3;
            6'h24: return m_both;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison of state-driven outputs
    always @(negedge clk) begin
        if (!rst) begin
            check("R8 irq", {31'b0, irq}, {31'b0, |(m_raw & m_en)});
            check("R2 pad_oe", pad_oe, ~m_dir);
            check("R2 pad_out", pad_out, m_out);
        end
    end

    task automatic wr(input bit [5:0] a, input bit [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input string tag, input bit [5:0] a);
        @(negedge clk);
        bus_addr = a;
        #2;
        check(tag, bus_rdata, exp_read(a));
    endtask

    task automatic rd_lit(input string tag, input bit [5:0] a, input bit [31:0] e);
        @(negedge clk);
        bus_addr = a;
        #2;
        check(tag, bus_rdata, e);
    endtask

    task automatic pads(input bit [31:0] v);
        @(negedge clk);
        pad_in = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        rd_lit("R1 enable", 6'h08, 32'h0);
        rd_lit("R1 pending", 6'h10, 32'h0);
        rd_lit("R1 direction", 6'h04, 32'hFFFF_FFFF);
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 pad_oe", pad_oe, 32'h0);
        // R9 version and reserved
        rd_lit("R9 version", 6'h20, 32'd3);
        rd_lit("R9 clear reads 0", 6'h14, 32'h0);
        rd_lit("R9 misaligned", 6'h21, 32'h0);

        // R2 direction and output
        wr(6'h04, 32'hFFFF_0000);
        wr(6'h00, 32'h0000_A5A5);
        check("R2 pad_oe literal", pad_oe, 32'h0000_FFFF);
        check("R2 pad_out literal", pad_out, 32'h0000_A5A5);
        wr(6'h05, 32'h0);
        rd_lit("R9 misaligned write ignored", 6'h04, 32'hFFFF_0000);

        // R3 readback mix
        pads(32'h1234_FFFF);
        idle(3);
        rd_lit("R3 level readback", 6'h00, 32'h1234_A5A5);
        rd("R3 model readback", 6'h00);
        wr(6'h04, 32'hFFFF_FFFF);
        pads(32'h0);
        idle(4);

        // R4 level mode: pins 0,2 active high, pins 1,3 active low
        wr(6'h1C, 32'h0000_0005);
        wr(6'h08, 32'h0000_000F);
        idle(3);
        rd_lit("R4 idle low", 6'h0C, 32'hFFFF_FFFA);
        rd_lit("R8 pending low", 6'h10, 32'h0000_000A);
        pads(32'h0000_000F);
        idle(3);
        rd_lit("R4 all high", 6'h0C, 32'hFFFF_FFF5);
        rd("R8 pending", 6'h10);
        // R7 level re-set while active
        wr(6'h14, 32'h0000_0001);
        rd("R7 level re-set", 6'h0C);
        pads(32'h0000_0005);
        idle(3);
        rd("R4 mixed", 6'h0C);

        // R5 edge mode: pins 4,5 rising, 6,7 falling
        wr(6'h08, 32'h0000_00F0);
        wr(6'h18, 32'h0000_00F0);
        wr(6'h1C, 32'h0000_0035);
        wr(6'h14, 32'h0000_00F0);
        rd_lit("R5 cleared", 6'h10, 32'h0);
        pads(32'h0000_00F5);
        idle(3);
        rd_lit("R5 rising only", 6'h10, 32'h0000_0030);
        pads(32'h0000_0005);
        idle(4);
        rd_lit("R5 latched both", 6'h10, 32'h0000_00F0);
        // R7 zero bits no effect, then selective clear
        wr(6'h14, 32'h0000_0000);
        rd_lit("R7 zero write", 6'h10, 32'h0000_00F0);
        wr(6'h14, 32'h0000_0050);
        rd_lit("R7 partial clear", 6'h10, 32'h0000_00A0);

        // R6 both-edge: pins 8,9 pol 1, pins 10,11 pol 0
        wr(6'h08, 32'h0000_0F00);
        wr(6'h18, 32'h0000_0FF0);
        wr(6'h24, 32'h0000_0F00);
        wr(6'h1C, 32'h0000_0335);
        wr(6'h14, 32'hFFFF_FFFF);
        pads(32'h0000_0F05);
        idle(3);
        rd_lit("R6 rise all", 6'h10, 32'h0000_0F00);
        wr(6'h14, 32'h0000_0F00);
        pads(32'h0000_0005);
        idle(3);
        rd_lit("R6 fall all", 6'h10, 32'h0000_0F00);
        wr(6'h14, 32'h0000_0F00);
        rd_lit("R6 cleared", 6'h10, 32'h0);

        // R7 coincident edge and clear: edge lands on third edge
        @(negedge clk);
        pad_in = 32'h0000_0105;
        @(negedge clk);
        @(negedge clk);
        bus_addr = 6'h14; bus_we = 1'b1; bus_wdata = 32'h0000_0100;
        @(negedge clk);
        bus_we = 1'b0;
        rd_lit("R7 event wins", 6'h10, 32'h0000_0100);
        rd("R7 model", 6'h0C);
        idle(3);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule